// File: doc/BRIEF.md
# Rate-Divided Auxiliary Target Scheduler

This block decides, once per sample tick, which auxiliary bus targets get a transaction in the coming round. Four periodic targets (indices 0 to 3) can each run at the full sample rate or at a reduced rate. A reduced-rate target runs once in every (1 + delay) accepted ticks. A fifth, one-shot target (index 4) runs after every periodic target chosen for the same round, and its enable is then cleared.

The scheduler sends one request at a time to an external bus engine, with the target index. It holds that request until the engine reports completion, and then moves to the next target. Completions produce one-cycle strobes: one that clears the enable of the one-shot target, a done pulse, a gated interrupt pulse, and a per-target NACK pulse. The status register that collects these pulses is outside this block.

Top module: `aux_sched`

## Requirements
- R1: After reset `req_valid` is 0, every output pulse is 0, and the shared phase counter is 0.
- R2: When a tick is accepted, each periodic target with its enable set and its reduced-rate bit clear becomes pending for that round. Pending targets are requested one at a time in ascending index order. The next request appears in the cycle after the completion of the previous one.
- R3: Reduced-rate targets are eligible only on accepted ticks where the shared phase is 0. Each accepted tick advances the phase by 1, and the phase returns to 0 after it reaches or exceeds the delay. A reduced-rate target therefore runs on the first tick after reset and then once every delay+1 accepted ticks.
- R4: With delay 0, reduced-rate targets are serviced on every accepted tick.
- R5: Target 4 is pending for a round if `os_en` is 1 when the tick is accepted. It is always requested after every periodic target of that round.
- R6: One cycle after the completion of a target-4 transaction, `os_en_clr` and `os_done` each pulse high for one cycle. Neither pulses for targets 0 to 3.
- R7: `os_irq` pulses together with `os_done` only if `os_irq_en` is 1 when the completion arrives.
- R8: A completion with `xfer_nack` high makes `nack_hit` pulse for one cycle, one cycle later, with only the bit of the completed target set (bit i = target i).
- R9: A tick that arrives while a round still has pending targets is ignored. It adds no pending target, leaves no backlog, and does not advance the phase.
- R10: While a request waits for completion, `req_valid` stays high and `req_tgt` does not change.
- R11: A disabled target is never requested. A tick with no eligible target produces no request.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| sample_tick | input | 1 | One-cycle sample-rate tick |
| per_en | input | N_PER | Enable per periodic target |
| per_slow | input | N_PER | Reduced-rate select per periodic target |
| rate_dly | input | DLY_W | Delay value; reduced rate is one tick in delay+1 |
| os_en | input | 1 | One-shot target enable |
| os_irq_en | input | 1 | Interrupt enable for one-shot completion |
| xfer_done | input | 1 | Bus engine completed the current request |
| xfer_nack | input | 1 | NACK qualifier, valid with xfer_done |
| req_valid | output | 1 | Transaction request outstanding |
| req_tgt | output | IW | Index of the requested target |
| os_en_clr | output | 1 | Strobe that clears the one-shot enable |
| os_done | output | 1 | One-shot transaction completed |
| os_irq | output | 1 | Gated one-shot interrupt pulse |
| nack_hit | output | N_PER+1 | Per-target NACK pulse |

## Verification
The bench tracks the shared phase across changes of delay and targets the alternating pattern at delay 1. A divider that advanced on every tick, or that counted ticks arriving mid-round, would skip or double a reduced-rate round. It sends a tick in the middle of a busy round: a design that queued the tick would issue a stray request afterwards, and one that advanced the phase would service a slow target a round early. Rounds that contain the one-shot target check that it comes last and that done, clear and a correctly gated interrupt appear exactly one cycle after completion. A NACK on target 2 or target 4 must set only that target's bit.

// File: rtl/aux_sched_pkg.sv
package aux_sched_pkg;
  localparam int MAX_TGT = 16;

  // Lowest set bit of a target mask; 0 when the mask is empty.
  function automatic int unsigned first_set(logic [MAX_TGT-1:0] v);
    int unsigned r;
    r = 0;
    for (int i = MAX_TGT - 1; i >= 0; i--) begin
      if (v[i]) r = i;
    end
    return r;
  endfunction
endpackage

// File: rtl/aux_rate_phase.sv
module aux_rate_phase #(
  parameter int DLY_W = 5
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             step,
  input  logic [DLY_W-1:0] dly,
  output logic             at_zero
);
  logic [DLY_W-1:0] phase;

  // Wrap once the limit is reached or exceeded (the limit may drop below phase).
  function automatic logic [DLY_W-1:0] next_phase(logic [DLY_W-1:0] cur,
                                                  logic [DLY_W-1:0] lim);
    return (cur >= lim) ? '0 : cur + 1'b1;
  endfunction

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    phase <= '0;
    else if (step) phase <= next_phase(phase, dly);
  end

  assign at_zero = (phase == '0);

  assert_wrap_R3: assert property (@(posedge clk) disable iff (!rst_n)
    step && (phase >= dly) |=> phase == '0);
  assert_step_R3: assert property (@(posedge clk) disable iff (!rst_n)
    step && (phase < dly) |=> phase == $past(phase) + 1'b1);
  assert_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
    !step |=> $stable(phase));
endmodule

// File: rtl/aux_pick.sv
module aux_pick #(
  parameter int NT = 5,
  parameter int IW = 3
) (
  input  logic [NT-1:0] pend,
  output logic [IW-1:0] idx,
  output logic          any
);
  import aux_sched_pkg::*;

  assign any = |pend;
  assign idx = IW'(first_set(MAX_TGT'(pend)));

  always_comb begin
    if (any) assert_pick_valid_R2: assert (pend[idx]);
  end
endmodule

// File: rtl/aux_sched.sv
module aux_sched #(
  parameter int N_PER = 4,
  parameter int DLY_W = 5,
  localparam int NT   = N_PER + 1,
  localparam int IW   = $clog2(NT)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             sample_tick,
  input  logic [N_PER-1:0] per_en,
  input  logic [N_PER-1:0] per_slow,
  input  logic [DLY_W-1:0] rate_dly,
  input  logic             os_en,
  input  logic             os_irq_en,
  input  logic             xfer_done,
  input  logic             xfer_nack,
  output logic             req_valid,
  output logic [IW-1:0]    req_tgt,
  output logic             os_en_clr,
  output logic             os_done,
  output logic             os_irq,
  output logic [NT-1:0]    nack_hit
);
  localparam int OS_IDX = N_PER;

  logic [NT-1:0] pending;
  logic [NT-1:0] elig;
  logic [NT-1:0] cur_bit;
  logic [IW-1:0] cur_idx;
  logic          busy;
  logic          slot_open;
  // Named internal events
  logic          tick_take;
  logic          done_take;
  logic          os_finish;

  assign tick_take = sample_tick && !busy;
  assign done_take = xfer_done && busy;
  assign os_finish = done_take && (cur_idx == IW'(OS_IDX));
  assign cur_bit   = NT'(1) << cur_idx;

  aux_rate_phase #(.DLY_W(DLY_W)) u_phase (
    .clk     (clk),
    .rst_n   (rst_n),
    .step    (tick_take),
    .dly     (rate_dly),
    .at_zero (slot_open)
  );

  aux_pick #(.NT(NT), .IW(IW)) u_pick (
    .pend (pending),
    .idx  (cur_idx),
    .any  (busy)
  );

  for (genvar g = 0; g < N_PER; g++) begin : g_elig
    assign elig[g] = per_en[g] && (!per_slow[g] || slot_open);
  end
  assign elig[OS_IDX] = os_en;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pending   <= '0;
      os_en_clr <= 1'b0;
      os_done   <= 1'b0;
      os_irq    <= 1'b0;
      nack_hit  <= '0;
    end else begin
      if (tick_take)      pending <= elig;
      else if (done_take) pending <= pending & ~cur_bit;
      os_en_clr <= os_finish;
      os_done   <= os_finish;
      os_irq    <= os_finish && os_irq_en;
      nack_hit  <= (done_take && xfer_nack) ? cur_bit : '0;
    end
  end

  assign req_valid = busy;
  assign req_tgt   = cur_idx;

  assert_hold_req_R10: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid && !xfer_done |=> req_valid && $stable(req_tgt));
  assert_ascending_R2: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid && xfer_done |=> !req_valid || (req_tgt > $past(req_tgt)));
  assert_os_last_R5: assert property (@(posedge clk) disable iff (!rst_n)
    os_done |-> !req_valid);
  assert_os_after_done_R6: assert property (@(posedge clk) disable iff (!rst_n)
    os_done |-> $past(xfer_done));
  assert_irq_gated_R7: assert property (@(posedge clk) disable iff (!rst_n)
    os_irq |-> os_done && $past(os_irq_en));
  assert_nack_single_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (nack_hit != '0) |-> ($countones(nack_hit) == 1) && $past(xfer_nack));
endmodule

// File: tb/aux_sched_test.sv
module aux_sched_test;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       sample_tick = 1'b0;
  logic [3:0] per_en = '0;
  logic [3:0] per_slow = '0;
  logic [4:0] rate_dly = '0;
  logic       os_en = 1'b0;
  logic       os_irq_en = 1'b0;
  logic       xfer_done = 1'b0;
  logic       xfer_nack = 1'b0;
  logic       req_valid;
  logic [2:0] req_tgt;
  logic       os_en_clr, os_done, os_irq;
  logic [4:0] nack_hit;

  int total = 0;
  int bad = 0;

  always #4 clk = ~clk;

  aux_sched uut (
    .clk(clk), .rst_n(rst_n), .sample_tick(sample_tick),
    .per_en(per_en), .per_slow(per_slow), .rate_dly(rate_dly),
    .os_en(os_en), .os_irq_en(os_irq_en),
    .xfer_done(xfer_done), .xfer_nack(xfer_nack),
    .req_valid(req_valid), .req_tgt(req_tgt),
    .os_en_clr(os_en_clr), .os_done(os_done), .os_irq(os_irq),
    .nack_hit(nack_hit)
  );

  typedef struct packed {
    logic [3:0] en;
    logic [3:0] slow;
    logic [4:0] dly;
    logic       os;
    logic       irq;
    logic [2:0] nk;   // 7 = no NACK
    logic [4:0] exp;
  } row_t;

  // Consecutive rounds starting from phase 0 after reset.
  localparam row_t VEC [13] = '{
    '{4'b1111, 4'b1111, 5'd0, 1'b0, 1'b0, 3'd7, 5'b01111},  // R4
    '{4'b1111, 4'b1111, 5'd0, 1'b0, 1'b0, 3'd7, 5'b01111},  // R4
    '{4'b0011, 4'b0010, 5'd1, 1'b0, 1'b0, 3'd0, 5'b00011},  // R3
    '{4'b0011, 4'b0010, 5'd1, 1'b0, 1'b0, 3'd7, 5'b00001},
    '{4'b0011, 4'b0010, 5'd1, 1'b0, 1'b0, 3'd7, 5'b00011},
    '{4'b0011, 4'b0010, 5'd1, 1'b0, 1'b0, 3'd7, 5'b00001},
    '{4'b1111, 4'b1100, 5'd2, 1'b1, 1'b1, 3'd2, 5'b11111},  // R5 R7 R8
    '{4'b1111, 4'b1100, 5'd2, 1'b0, 1'b0, 3'd7, 5'b00011},
    '{4'b1111, 4'b1100, 5'd2, 1'b0, 1'b0, 3'd7, 5'b00011},
    '{4'b0101, 4'b1100, 5'd2, 1'b1, 1'b0, 3'd4, 5'b10101},  // R7 gated off
    '{4'b0000, 4'b0000, 5'd2, 1'b1, 1'b1, 3'd7, 5'b10000},
    '{4'b0000, 4'b0000, 5'd2, 1'b0, 1'b0, 3'd7, 5'b00000},  // R11
    '{4'b1000, 4'b1000, 5'd2, 1'b0, 1'b0, 3'd7, 5'b01000}
  };

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s act=%0d exp=%0d", req, act, exp);
    end
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 1'b0; sample_tick = 0; per_en = '0; per_slow = '0; rate_dly = '0;
    os_en = 0; os_irq_en = 0; xfer_done = 0; xfer_nack = 0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
  endtask

  task automatic run_round(input logic [3:0] en, input logic [3:0] slow,
                           input logic [4:0] d, input logic os, input logic irq,
                           input int nk, input bit poke, output logic [4:0] seen);
    int  last;
    int  guard;
    int  t;
    bit  poked;
    seen = '0; last = -1; guard = 0; poked = 0;
    @(negedge clk);
    per_en = en; per_slow = slow; rate_dly = d; os_en = os; os_irq_en = irq;
    sample_tick = 1'b1;
    @(negedge clk);
    sample_tick = 1'b0;
    while (req_valid && guard < 10) begin
      t = int'(req_tgt);
      chk(t > last, "R2 ascending order", t, last + 1);
      chk(t == 4 || en[t], "R11 disabled target requested", t, 4);
      seen[t] = 1'b1;
      if (poke && !poked) begin
        sample_tick = 1'b1;
        @(negedge clk);
        sample_tick = 1'b0;
        poked = 1;
        chk(req_valid && int'(req_tgt) == t, "R10 request held", int'(req_tgt), t);
      end
      xfer_done = 1'b1;
      xfer_nack = (t == nk);
      @(negedge clk);
      xfer_done = 1'b0;
      xfer_nack = 1'b0;
      chk(os_done == (t == 4), "R6 done pulse", os_done, t == 4);
      chk(os_en_clr == (t == 4), "R6 enable clear", os_en_clr, t == 4);
      chk(os_irq == (t == 4 && irq), "R7 interrupt gate", os_irq, t == 4 && irq);
      chk(nack_hit == ((t == nk) ? (5'b1 << t) : 5'b0), "R8 nack bit",
          nack_hit, (t == nk) ? (1 << t) : 0);
      if (os_en_clr) os_en = 1'b0;
      last = t;
      guard++;
    end
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    bad++; total++;
    $display("FAIL R2 watchdog act=hung exp=finished");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    logic [4:0] seen;
    do_reset();
    @(negedge clk);
    // R1 reset state
    chk(req_valid == 0, "R1 req_valid", req_valid, 0);
    chk(os_done == 0 && os_en_clr == 0 && os_irq == 0, "R1 one-shot pulses",
        {os_done, os_en_clr, os_irq}, 0);
    chk(nack_hit == 0, "R1 nack_hit", nack_hit, 0);

    // Table walk: R2 R3 R4 R5 R11
    for (int k = 0; k < 13; k++) begin
      run_round(VEC[k].en, VEC[k].slow, VEC[k].dly, VEC[k].os, VEC[k].irq,
                int'(VEC[k].nk), 1'b0, seen);
      chk(seen == VEC[k].exp, "R2/R3/R5 round mask", seen, VEC[k].exp);
    end

    // R9: tick during a busy round is dropped, phase not advanced
    do_reset();
    run_round(4'b0011, 4'b0001, 5'd1, 1'b0, 1'b0, 7, 1'b1, seen);
    chk(seen == 5'b00011, "R9 round with mid tick", seen, 5'b00011);
    repeat (3) @(negedge clk);
    chk(req_valid == 0, "R9 no backlog request", req_valid, 0);
    run_round(4'b0011, 4'b0001, 5'd1, 1'b0, 1'b0, 7, 1'b0, seen);
    chk(seen == 5'b00010, "R9 phase not advanced", seen, 5'b00010);

    // R3: delay 3, slow target every fourth accepted tick from reset
    do_reset();
    for (int k = 0; k < 8; k++) begin
      run_round(4'b1000, 4'b1000, 5'd3, 1'b0, 1'b0, 7, 1'b0, seen);
      chk(seen == ((k % 4 == 0) ? 5'b01000 : 5'b00000), "R3 divide by four",
          seen, (k % 4 == 0) ? 8 : 0);
    end

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule